// File: doc/BRIEF.md
# Key-Protected Real-Time Clock Timekeeper

This block keeps wall-clock time from a 32.768 kHz source. It holds four 8-bit counters: hundredths of a second, seconds, minutes and hours. A fractional prescaler turns the source clock into exactly 100 hundredths ticks per second. Each counter wraps at its last value and carries into the next counter in the same clock cycle. A configuration bit sets the hour counter to wrap either after 23 or after 255. Each hour wrap raises a midnight event. The event sets a sticky flag and drives a one-cycle pulse out of the block.

Software uses a simple synchronous register port. A write takes effect at the clock edge on which `bus_we` is high. Reads are combinational and show the live counters; the clock never stops. So a reader that reads several bytes has to re-read if the hundredths value wrapped during the read. A stray write must not change the time. A timekeeping write is therefore accepted only while the key register holds the unlock value. The key register clears itself after every accepted timekeeping write, so each write needs the key loaded again first.

Top module: `rtc_keyed_timekeeper`

## Requirements
- R1: After a synchronous active-low reset, the following all read 0: every counter, the key register and the configuration register. `midnight_pulse` is 0.
- R2: The hundredths counter advances once every 327 or 328 clock cycles. Any 100 consecutive advances span exactly 32768 clock cycles.
- R3: Hundredths wrap 99 to 0 and then carry into seconds. Seconds and minutes wrap 59 to 0 and carry onward. The counters affected by one carry chain all update on the same clock edge.
- R4: A write to a timekeeping address is accepted only while the key register (address 0x08) holds 0xEA. The timekeeping addresses are hundredths 0x01, seconds 0x02, minutes 0x03 and hours 0x04.
- R5: After an accepted timekeeping write, the key register reads 0. A following timekeeping write that is not preceded by a new key is ignored.
- R6: A timekeeping write made without the correct key leaves the counter and the key register unchanged. The counters keep advancing.
- R7: When configuration bit 0 is 0, the hours counter wraps from 23 to 0 and raises a midnight event.
- R8: When configuration bit 0 is 1, the hours counter passes 23 to 24 without an event. It wraps from 255 to 0 and raises a midnight event.
- R9: A midnight event sets configuration bit 7, and the bit stays set. Writing the configuration register with bit 7 = 0 clears the bit. Writing bit 7 = 1 has no effect on it.
- R10: `midnight_pulse` is high for exactly one cycle per midnight event. That is the cycle in which the hours first read 0 and bit 7 first reads 1.
- R11: `bus_rdata` shows the addressed register in the same cycle. The configuration register at 0x00 reads as {flag, 6'b0, mode}. Unmapped addresses read 0.
- R12: A counter that was written with a value at or above its wrap value returns to 0 on its next carry-in and passes the carry on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timekeeping clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Live read data of the addressed register |
| midnight_pulse | output | 1 | One-cycle pulse on each hour wrap |

## Verification
The embedded properties check several behaviours on every cycle:
- the prescaler spacing of 327 or 328 cycles between ticks;
- the step, wrap and hold rules of each counter, including wraps from out-of-range values;
- the automatic clearing of the key after an accepted write;
- that a write with the wrong key leaves all counters unchanged;
- that the pulse and the midnight flag agree, and the hours read 0 at the event.

Other behaviours only the bench scenarios can show. These are the exact 32768-cycle span of 100 ticks and the full carry cascade from hundredths into hours. They also include the choice between 24-hour and 256-hour wraps, the effect of software writes on the flag, and the register map as seen through live reads.

// File: rtl/rtc_tk_pkg.sv
// Shared constants for the key-protected real-time clock timekeeper.
// Assumes an 8-bit register port. The four timekeeping counters sit at
// consecutive addresses, hundredths first.
package rtc_tk_pkg;

    localparam int DW     = 8;
    localparam int AW     = 8;
    localparam int NSTAGE = 4;

    localparam logic [AW-1:0] A_CFG  = 8'h00;
    localparam logic [AW-1:0] A_HUND = 8'h01;
    localparam logic [AW-1:0] A_SEC  = 8'h02;
    localparam logic [AW-1:0] A_MIN  = 8'h03;
    localparam logic [AW-1:0] A_HOUR = 8'h04;
    localparam logic [AW-1:0] A_KEY  = 8'h08;

    localparam int CFG_WIDE_BIT = 0;
    localparam int CFG_MID_BIT  = 7;

    // Last value before wrap for each stage. Only the hour stage depends on the mode.
    function automatic logic [DW-1:0] stage_last(input int idx, input logic wide);
        case (idx)
            0:       return DW'(99);
            1, 2:    return DW'(59);
            default: return wide ? DW'(255) : DW'(23);
        endcase
    endfunction

endpackage

// File: rtl/rtc_frac_prescaler.sv
// Fractional divider: emits a one-cycle tick TICK_HZ times per SRC_HZ cycles.
// It uses a phase accumulator, so periods alternate between floor and ceil of
// SRC_HZ/TICK_HZ. Assumes TICK_HZ < SRC_HZ.
module rtc_frac_prescaler #(
    parameter int SRC_HZ  = 32768,
    parameter int TICK_HZ = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int ACC_W = $clog2(SRC_HZ + TICK_HZ + 1);
    localparam logic [ACC_W-1:0] STEP   = ACC_W'(TICK_HZ);
    localparam logic [ACC_W-1:0] MODULO = ACC_W'(SRC_HZ);
    localparam logic [ACC_W-1:0] THRESH = ACC_W'(SRC_HZ - TICK_HZ);
    localparam int PER_LO = SRC_HZ / TICK_HZ;
    localparam int GAP_W  = $clog2(PER_LO + 2);

    logic [ACC_W-1:0] acc_q;

    // Tick whenever adding one more step would reach the modulus.
    always_comb tick = (acc_q >= THRESH);

    // Advance the phase accumulator, removing one modulus per tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc_q <= '0;
        else if (tick) acc_q <= acc_q + STEP - MODULO;
        else           acc_q <= acc_q + STEP;
    end

    // Checker state: cycles since the last tick, and whether one was seen.
    logic [GAP_W-1:0] gap_q;
    logic             seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (tick) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    p_tick_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && seen_q) |-> (gap_q == GAP_W'(PER_LO - 1) || gap_q == GAP_W'(PER_LO)));

    p_acc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < MODULO);

endmodule

// File: rtl/rtc_wrap_stage.sv
// One counter of the time chain. On carry-in it steps by one, or returns to
// 0 when at or above last_val. A write replaces the count. carry_out reflects
// the count before any write in that cycle, so a carry already leaving still
// propagates.
module rtc_wrap_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         carry_in,
    input  logic [W-1:0] last_val,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] value,
    output logic         carry_out
);
    logic at_end;

    // Wrap condition also catches out-of-range written values.
    always_comb at_end = (value >= last_val);
    always_comb carry_out = carry_in && at_end;

    // Update the count: a write wins, otherwise step or wrap on carry.
    always_ff @(posedge clk) begin
        if (!rst_n)        value <= '0;
        else if (wr_en)    value <= wr_data;
        else if (carry_in) value <= at_end ? '0 : value + 1'b1;
    end

    p_wrap_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_in && !wr_en && value >= last_val) |=> (value == '0));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (carry_in && !wr_en && value < last_val) |=> (value == $past(value) + 1'b1));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!carry_in && !wr_en) |=> $stable(value));

endmodule

// File: rtl/rtc_key_gate.sv
// Write-protection key. The key register is loaded by key_wr. A timekeeping
// write request is granted only while the key equals KEY_VALUE. The key then
// clears itself after each grant. Assumes key_wr and tk_wr_req never coincide,
// since both come from address decode.
module rtc_key_gate #(
    parameter int            W         = 8,
    parameter logic [W-1:0]  KEY_VALUE = 8'hEA
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         key_wr,
    input  logic [W-1:0] key_wdata,
    input  logic         tk_wr_req,
    output logic [W-1:0] key_q,
    output logic         tk_wr_ok
);
    // Grant only against a matching key.
    always_comb tk_wr_ok = tk_wr_req && (key_q == KEY_VALUE);

    // Load on key write, drop the unlock after each granted write.
    always_ff @(posedge clk) begin
        if (!rst_n)        key_q <= '0;
        else if (key_wr)   key_q <= key_wdata;
        else if (tk_wr_ok) key_q <= '0;
    end

    p_relock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tk_wr_ok && !key_wr) |=> (key_q == '0));

    p_key_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_wr && !tk_wr_ok) |=> $stable(key_q));

endmodule

// File: rtl/rtc_keyed_timekeeper.sv
// Top of the key-protected real-time clock timekeeper. It chains four wrap
// stages behind a fractional prescaler and decodes a synchronous register port
// with live combinational reads. Timekeeping writes are gated by the key. The
// hour wrap sets a sticky midnight flag and sends a one-cycle pulse. Assumes
// clk is the 32.768 kHz timekeeping clock.
module rtc_keyed_timekeeper
    import rtc_tk_pkg::*;
#(
    parameter int            SRC_HZ    = 32768,
    parameter int            TICK_HZ   = 100,
    parameter logic [DW-1:0] KEY_VALUE = 8'hEA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          midnight_pulse
);
    localparam int FLAT_W = NSTAGE * DW;

    logic              tick;
    logic [NSTAGE:0]   carry;
    logic [DW-1:0]     cnt_q [NSTAGE];
    logic [FLAT_W-1:0] cnt_flat;
    logic              wide_mode;
    logic              mid_flag;
    logic              is_tk, tk_wr_req, key_wr, cfg_wr, tk_wr_ok;
    logic [DW-1:0]     key_q;

    // Decode the register port into write classes.
    always_comb begin
        is_tk     = (bus_addr >= A_HUND) && (bus_addr <= A_HOUR);
        tk_wr_req = bus_we && is_tk;
        key_wr    = bus_we && (bus_addr == A_KEY);
        cfg_wr    = bus_we && (bus_addr == A_CFG);
    end

    rtc_frac_prescaler #(.SRC_HZ(SRC_HZ), .TICK_HZ(TICK_HZ)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rtc_key_gate #(.W(DW), .KEY_VALUE(KEY_VALUE)) u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .key_wr    (key_wr),
        .key_wdata (bus_wdata),
        .tk_wr_req (tk_wr_req),
        .key_q     (key_q),
        .tk_wr_ok  (tk_wr_ok)
    );

    assign carry[0] = tick;

    // Counter chain: stage i sits at A_HUND + i and wraps at stage_last(i).
    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        localparam logic [AW-1:0] STAGE_ADDR = A_HUND + AW'(i);
        logic          st_wr;
        logic [DW-1:0] st_last;

        always_comb st_wr   = tk_wr_ok && (bus_addr == STAGE_ADDR);
        always_comb st_last = stage_last(i, wide_mode);

        rtc_wrap_stage #(.W(DW)) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .carry_in  (carry[i]),
            .last_val  (st_last),
            .wr_en     (st_wr),
            .wr_data   (bus_wdata),
            .value     (cnt_q[i]),
            .carry_out (carry[i+1])
        );

        assign cnt_flat[i*DW +: DW] = cnt_q[i];
    end

    // Hour-mode bit follows configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n)      wide_mode <= 1'b0;
        else if (cfg_wr) wide_mode <= bus_wdata[CFG_WIDE_BIT];
    end

    // Sticky midnight flag: the event sets it (and wins), a written 0 clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 mid_flag <= 1'b0;
        else if (carry[NSTAGE])                     mid_flag <= 1'b1;
        else if (cfg_wr && !bus_wdata[CFG_MID_BIT]) mid_flag <= 1'b0;
    end

    // One-cycle midnight pulse aligned with the wrapped hour value.
    always_ff @(posedge clk) begin
        if (!rst_n) midnight_pulse <= 1'b0;
        else        midnight_pulse <= carry[NSTAGE];
    end

    // Live read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CFG: begin
                bus_rdata[CFG_MID_BIT]  = mid_flag;
                bus_rdata[CFG_WIDE_BIT] = wide_mode;
            end
            A_HUND:  bus_rdata = cnt_q[0];
            A_SEC:   bus_rdata = cnt_q[1];
            A_MIN:   bus_rdata = cnt_q[2];
            A_HOUR:  bus_rdata = cnt_q[3];
            A_KEY:   bus_rdata = key_q;
            default: bus_rdata = '0;
        endcase
    end

    p_pulse_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        midnight_pulse |-> mid_flag);

    p_pulse_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        midnight_pulse |=> !midnight_pulse);

    p_flag_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mid_flag) |-> midnight_pulse);

    p_locked_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tk_wr_req && key_q != KEY_VALUE && !tick) |=> $stable(cnt_flat));

    p_key_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tk_wr_req && key_q == KEY_VALUE && bus_addr == A_SEC) |=> (cnt_q[1] == $past(bus_wdata)));

    p_midnight_hour_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (midnight_pulse && !$past(tk_wr_ok && bus_addr == A_HOUR)) |-> (cnt_q[3] == '0));

endmodule

// File: tb/tb_rtc_keyed_timekeeper.sv
// Scoreboard bench: driver tasks queue expected register reads, a monitor
// pops and compares them at the falling edge.
module tb_rtc_keyed_timekeeper;
    import rtc_tk_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          midnight_pulse;

    int checks = 0;
    int errors = 0;
    int pulse_cnt = 0;
    bit probe = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [DW-1:0] exp;
        string         tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    rtc_keyed_timekeeper dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_we         (bus_we),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .midnight_pulse (midnight_pulse)
    );

    // Count cycles with the midnight pulse high.
    always @(negedge clk) if (rst_n && midnight_pulse) pulse_cnt++;

    // Monitor: pop the expected item and compare with the live read.
    always @(negedge clk) begin
        sb_item_t it;
        if (probe) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty actual %h expected item", bus_rdata);
            end else begin
                it = sb_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr %h actual %h expected %h", it.tag, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic check_eq(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(posedge clk); #2;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_we = 1'b0;
    endtask

    task automatic key_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_write(A_KEY, 8'hEA);
        bus_write(a, d);
    endtask

    task automatic expect_reg(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        sb_item_t it;
        @(posedge clk); #2;
        bus_addr = a;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        probe = 1'b1;
        @(negedge clk); #1;
        probe = 1'b0;
    endtask

    task automatic read_now(input logic [AW-1:0] a, output logic [DW-1:0] v);
        @(posedge clk); #2;
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    // Wait until hundredths read 0 (the wrap after a written 99).
    task automatic wait_hund_zero();
        @(posedge clk); #2;
        bus_addr = A_HUND;
        for (int n = 0; n < 1000; n++) begin
            @(negedge clk);
            if (bus_rdata == 8'd0) break;
        end
        @(posedge clk);
    endtask

    // Load h:m:s with hundredths at 99 and let the carry chain ripple.
    task automatic roll_from(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        key_write(A_HUND, 8'd0);
        key_write(A_HOUR, h);
        key_write(A_MIN, m);
        key_write(A_SEC, s);
        key_write(A_HUND, 8'd99);
        wait_hund_zero();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v1, v2;
        int prev, cyc, nchg, bad, first_chg, last_chg, gap;

        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: reset state
        expect_reg(A_CFG, 8'h00, "R1 cfg");
        expect_reg(A_HUND, 8'h00, "R1 hund");
        expect_reg(A_SEC, 8'h00, "R1 sec");
        expect_reg(A_MIN, 8'h00, "R1 min");
        expect_reg(A_HOUR, 8'h00, "R1 hour");
        expect_reg(A_KEY, 8'h00, "R1 key");
        check_eq(int'(midnight_pulse), 0, "R1 pulse");
        // R11: unmapped address reads zero
        expect_reg(8'h05, 8'h00, "R11 unmapped");

        // R2: prescaler spacing over 100 consecutive advances
        @(posedge clk); #2 bus_addr = A_HUND;
        @(negedge clk);
        prev = int'(bus_rdata);
        cyc = 0; nchg = 0; bad = 0; first_chg = 0; last_chg = 0;
        while (nchg < 101) begin
            @(negedge clk);
            cyc++;
            if (int'(bus_rdata) != prev) begin
                prev = int'(bus_rdata);
                if (nchg > 0) begin
                    gap = cyc - last_chg;
                    if (gap != 327 && gap != 328) bad++;
                end else begin
                    first_chg = cyc;
                end
                last_chg = cyc;
                nchg++;
            end
        end
        check_eq(bad, 0, "R2 tick gaps");
        check_eq(last_chg - first_chg, 32768, "R2 span of 100 ticks");

        // R4 / R5: keyed write accepted, key clears, unkeyed write ignored
        key_write(A_HUND, 8'd0);
        expect_reg(A_KEY, 8'h00, "R5 key cleared");
        key_write(A_SEC, 8'd30);
        expect_reg(A_SEC, 8'd30, "R4 keyed write");
        bus_write(A_SEC, 8'd12);
        expect_reg(A_SEC, 8'd30, "R5 write without re-key");

        // R6: wrong key rejected, key kept, counting continues
        bus_write(A_KEY, 8'h5A);
        bus_write(A_SEC, 8'd7);
        expect_reg(A_SEC, 8'd30, "R6 wrong key write");
        expect_reg(A_KEY, 8'h5A, "R6 key unchanged");
        read_now(A_HUND, v1);
        repeat (700) @(posedge clk);
        read_now(A_HUND, v2);
        check_eq(int'(v1 != v2), 1, "R6 hundredths still advancing");

        // R3 / R7 / R9 / R10: full cascade and midnight in 24-hour mode
        bus_write(A_CFG, 8'h00);
        roll_from(8'd23, 8'd59, 8'd59);
        expect_reg(A_SEC, 8'd0, "R3 sec wrap");
        expect_reg(A_MIN, 8'd0, "R3 min wrap");
        expect_reg(A_HOUR, 8'd0, "R7 hour 23 to 0");
        expect_reg(A_CFG, 8'h80, "R9 flag set");
        check_eq(pulse_cnt, 1, "R10 single pulse");

        // R9: writing 1 keeps, writing 0 clears, writing 1 cannot set
        bus_write(A_CFG, 8'h80);
        expect_reg(A_CFG, 8'h80, "R9 write 1 no effect");
        bus_write(A_CFG, 8'h00);
        expect_reg(A_CFG, 8'h00, "R9 write 0 clears");
        bus_write(A_CFG, 8'h80);
        expect_reg(A_CFG, 8'h00, "R9 write 1 does not set");

        // R3: minute carry into hour without midnight
        roll_from(8'd5, 8'd59, 8'd59);
        expect_reg(A_HOUR, 8'd6, "R3 hour step");
        expect_reg(A_MIN, 8'd0, "R3 minute wrap");
        check_eq(pulse_cnt, 1, "R3 no pulse on hour step");

        // R8: 256-hour mode
        bus_write(A_CFG, 8'h01);
        roll_from(8'd23, 8'd59, 8'd59);
        expect_reg(A_HOUR, 8'd24, "R8 hour 23 to 24");
        expect_reg(A_CFG, 8'h01, "R8 no flag at 24");
        check_eq(pulse_cnt, 1, "R8 no pulse at 24");
        roll_from(8'd255, 8'd59, 8'd59);
        expect_reg(A_HOUR, 8'd0, "R8 hour 255 to 0");
        expect_reg(A_CFG, 8'h81, "R8 flag at 255 wrap");
        check_eq(pulse_cnt, 2, "R8 pulse at 255 wrap");

        // R12: out-of-range written values wrap on next carry
        bus_write(A_CFG, 8'h00);
        roll_from(8'd2, 8'd10, 8'd75);
        expect_reg(A_SEC, 8'd0, "R12 sec 75 wraps");
        expect_reg(A_MIN, 8'd11, "R12 carry passed on");
        roll_from(8'd40, 8'd59, 8'd59);
        expect_reg(A_HOUR, 8'd0, "R12 hour 40 wraps in 24h mode");
        check_eq(pulse_cnt, 3, "R12 midnight from out-of-range hour");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule